// File: doc/BRIEF.md
# Memory-to-Stream DMA Read Channel

The block moves a run of 32-bit words from memory onto a valid/ready stream. Software gives a start address, a length counted in 4-byte words, an end-of-message option, a byte-order option and an outstanding-read limit, then pulses a start strobe. The channel sends one-word read requests to a simple request/response memory port and collects the returned words in an internal FIFO. It then drains the FIFO onto the stream. On the final word of the command it can mark the end of the message.

Two pause inputs act independently. The memory pause holds back new read requests. The stream pause holds back the FIFO drain. While the channel runs, the next read address, the words still to be delivered and a running 32-bit sum of every word read from memory can all be read.

A controller state machine has four states. IDLE goes to FETCH on an accepted start (go). FETCH goes to DRAIN when the final read request is accepted (issued_all). DRAIN goes to DONE when the final word is handed to the stream (sent_all). DONE goes back to IDLE after one cycle (retire).

Top module: `strm_rd_dma`

## Requirements
- R1: A start strobe is accepted only in IDLE and only with a nonzero word count. Busy is high from the cycle after an accepted start. A strobe while busy, or one with a zero count, changes nothing: no request is issued and the running command keeps its address and length.
- R2: Read requests carry the addresses start, start+4, start+8 and so on, one per word. The two low bits of the start address are taken as zero.
- R3: A read request is offered only while the outstanding reads are below the limit and the FIFO plus the outstanding reads hold fewer than FIFO_DEPTH words. The limit is max_out+1 for max_out 0..8, and 9 for any larger value.
- R4: Stream words come out in request order. With the swap option at 1, byte 0 (bits 7:0) and byte 3 (bits 31:24) trade places, and so do bytes 1 and 2. With the option at 0 the word passes unchanged.
- R5: With the end-of-message option at 1, last is high together with valid on the final word of the command and on no other word. With the option at 0, last stays low for the whole command.
- R6: While the memory pause is high, no read request is offered, but responses already owed are still accepted. Lowering the pause resumes issue at the next address.
- R7: While the stream pause is high, stream valid is low. Lowering the pause resumes the drain with no word lost or repeated.
- R8: The checksum is the sum, modulo 2^32, of every raw word returned by memory before any byte swap. It keeps accumulating across commands. The clear input zeroes it in the next cycle, and a clear wins over a word that arrives in the same cycle.
- R9: The current address output gives the address of the next read request. The words-left output gives the words not yet handed to the stream. Both are correct while the channel runs and while it is paused.
- R10: Done is a one-cycle pulse in the cycle after the final stream handshake. Busy falls together with the end of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start strobe |
| cfg_addr | input | ADDR_W | Start byte address |
| cfg_words | input | LEN_W | Number of 32-bit words |
| cfg_eom | input | 1 | Mark the final word with last |
| cfg_swap | input | 1 | Reverse the byte order of each word |
| cfg_max_out | input | 4 | Outstanding-read limit code |
| pause_mem | input | 1 | Hold back new read requests |
| pause_strm | input | 1 | Hold back the FIFO drain |
| sum_clr | input | 1 | Clear the checksum |
| mem_req_valid | output | 1 | Read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read request address |
| mem_rsp_valid | input | 1 | Read data returned, in request order |
| mem_rsp_data | input | 32 | Returned word |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | Final word of the message |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completion pulse |
| cur_addr | output | ADDR_W | Next read address |
| words_left | output | LEN_W | Words not yet delivered |
| chksum | output | 32 | Running sum of read data |

## Verification
The transfer is tried with several patterns:
- A short command with an always-ready memory and sink, which isolates the address sequence, the data order and the placement of last.
- A misaligned start with the byte swap and gappy ready and response patterns, which separates swapped from unswapped data and shows that stalls on either side neither drop nor repeat words.
- A long command with the stream paused and the highest limit, which fills the FIFO and shows the FIFO-room rule apart from the outstanding limit.
- A command paused on the memory side, and one with an over-range limit code that must clamp to nine.

Stray strobes during a run, a zero-length start and a clear that lands in the same cycle as a returning word settle the ignore and priority rules.

// File: rtl/strm_dma_pkg.sv
package strm_dma_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OUT_CAP  = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_DONE
    } dma_state_e;

    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[8*b +: 8] = w[WORD_W - 8*(b+1) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/strm_dma_fifo.sv
module strm_dma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty
);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_pop;

    assign empty  = (count == '0);
    assign do_pop = pop && !empty;
    assign rdata  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            unique case ({push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/strm_dma_issue.sv
module strm_dma_issue #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int OW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [3:0]        max_out,
    input  logic              run,
    input  logic              pause,
    input  logic [CW-1:0]     fifo_cnt,
    input  logic              rsp_valid,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [OW-1:0]     out_cnt,
    output logic              fire_last
);

    localparam logic [3:0] CODE_TOP = 4'(strm_dma_pkg::OUT_CAP - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [3:0]        max_q;
    logic [OW-1:0]     limit;
    logic              room;
    logic              fire;

    assign limit    = (max_q > CODE_TOP) ? OW'(strm_dma_pkg::OUT_CAP) : max_q + OW'(1);
    assign room     = ({1'b0, fifo_cnt} + (CW+1)'(out_cnt)) < (CW+1)'(DEPTH);
    assign req_valid = run && !pause && (left_q != '0) && (out_cnt < limit) && room;
    assign fire      = req_valid && req_ready;
    assign fire_last = fire && (left_q == LEN_W'(1));
    assign req_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            max_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr & ~ADDR_W'(3);
            left_q <= load_len;
            max_q  <= max_out;
        end else if (fire) begin
            addr_q <= addr_q + ADDR_W'(4);
            left_q <= left_q - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt <= '0;
        end else begin
            unique case ({fire, rsp_valid && (out_cnt != '0)})
                2'b10:   out_cnt <= out_cnt + OW'(1);
                2'b01:   out_cnt <= out_cnt - OW'(1);
                default: out_cnt <= out_cnt;
            endcase
        end
    end

endmodule

// File: rtl/strm_dma_sum.sv
module strm_dma_sum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] sum
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + add_val;
        end
    end

endmodule

// File: rtl/strm_rd_dma.sv
module strm_rd_dma
    import strm_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 16,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_words,
    input  logic              cfg_eom,
    input  logic              cfg_swap,
    input  logic [3:0]        cfg_max_out,
    input  logic              pause_mem,
    input  logic              pause_strm,
    input  logic              sum_clr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [31:0]       st_data,
    output logic              st_last,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  words_left,
    output logic [31:0]       chksum
);

    dma_state_e        state_q, state_d;
    logic              go;
    logic              fetch_en;
    logic              drain_en;
    logic              fire_last;
    logic              st_fire;
    logic [3:0]        out_cnt;
    logic [CW-1:0]     fifo_cnt;
    logic              fifo_empty;
    logic [31:0]       fifo_word;
    logic [LEN_W-1:0]  left_q;
    logic              eom_q;
    logic              swap_q;

    assign go = (state_q == ST_IDLE) && cfg_start && (cfg_words != '0);

    strm_dma_issue #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DEPTH  (FIFO_DEPTH)
    ) issue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .load_addr (cfg_addr),
        .load_len  (cfg_words),
        .max_out   (cfg_max_out),
        .run       (fetch_en),
        .pause     (pause_mem),
        .fifo_cnt  (fifo_cnt),
        .rsp_valid (mem_rsp_valid),
        .req_ready (mem_req_ready),
        .req_valid (mem_req_valid),
        .req_addr  (mem_req_addr),
        .out_cnt   (out_cnt),
        .fire_last (fire_last)
    );

    strm_dma_fifo #(
        .W     (32),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mem_rsp_valid),
        .wdata (mem_rsp_data),
        .pop   (st_fire),
        .rdata (fifo_word),
        .count (fifo_cnt),
        .empty (fifo_empty)
    );

    strm_dma_sum #(
        .W (32)
    ) sum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sum_clr),
        .add_en  (mem_rsp_valid),
        .add_val (mem_rsp_data),
        .sum     (chksum)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)                                       state_d = ST_FETCH;
            ST_FETCH: if (fire_last)                                state_d = ST_DRAIN;
            ST_DRAIN: if (st_fire && (left_q == LEN_W'(1)))         state_d = ST_DONE;
            ST_DONE:                                                state_d = ST_IDLE;
            default:                                                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // state outputs
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        fetch_en = 1'b0;
        drain_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_FETCH: begin
                fetch_en = 1'b1;
                drain_en = 1'b1;
            end
            ST_DRAIN: drain_en = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign st_valid   = drain_en && !fifo_empty && !pause_strm;
    assign st_fire    = st_valid && st_ready;
    assign st_last    = st_valid && eom_q && (left_q == LEN_W'(1));
    assign st_data    = swap_q ? byte_rev(fifo_word) : fifo_word;
    assign words_left = left_q;
    assign cur_addr   = mem_req_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            eom_q  <= 1'b0;
            swap_q <= 1'b0;
        end else if (go) begin
            left_q <= cfg_words;
            eom_q  <= cfg_eom;
            swap_q <= cfg_swap;
        end else if (st_fire) begin
            left_q <= left_q - LEN_W'(1);
        end
    end

endmodule

// File: rtl/strm_dma_chk.sv
module strm_dma_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             mem_req_valid,
    input logic             pause_mem,
    input logic             pause_strm,
    input logic             st_valid,
    input logic             st_ready,
    input logic             st_last,
    input logic             sum_clr,
    input logic [31:0]      chksum,
    input logic [LEN_W-1:0] words_left,
    input logic [3:0]       out_cnt
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !st_valid)); // R1

    AST_OUT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= 4'd9); // R3

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        st_last |-> st_valid); // R5

    AST_MEM_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_mem |-> !mem_req_valid); // R6

    AST_STRM_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_strm |-> !st_valid); // R7

    AST_SUM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sum_clr |=> (chksum == 32'd0)); // R8

    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> (words_left == $past(words_left) - LEN_W'(1))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10

endmodule

bind strm_rd_dma strm_dma_chk #(
    .LEN_W (LEN_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .pause_mem     (pause_mem),
    .pause_strm    (pause_strm),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .st_last       (st_last),
    .sum_clr       (sum_clr),
    .chksum        (chksum),
    .words_left    (words_left),
    .out_cnt       (out_cnt)
);

// File: tb/strm_rd_dma_tb_top.sv
`timescale 1ns/100ps
module strm_rd_dma_tb_top;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_start;
    logic [ADDR_W-1:0] cfg_addr;
    logic [LEN_W-1:0]  cfg_words;
    logic              cfg_eom, cfg_swap;
    logic [3:0]        cfg_max_out;
    logic              pause_mem, pause_strm, sum_clr;
    logic              mem_req_valid, mem_req_ready;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid;
    logic [31:0]       mem_rsp_data;
    logic              st_valid, st_ready, st_last;
    logic [31:0]       st_data;
    logic              busy, done;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  words_left;
    logic [31:0]       chksum;

    always #2 clk = ~clk;

    strm_rd_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) dut_i (.*);

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          hs_last_cyc = -10;
    int          issued = 0;
    int          delivered = 0;
    int          lim_now = 1;
    int          mem_mode = 0;
    int          st_mode = 0;
    logic [31:0] exp_addr = '0;
    logic [31:0] exp_sum = '0;
    logic [32:0] exp_q [$];
    logic [31:0] pend_q [$];

    function automatic logic [31:0] dfun(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A17_C0DE;
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // memory model and stream monitor (scoreboard consumer)
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        st_ready      = 1'b0;
        forever begin
            int          ob;
            logic [31:0] d;
            logic [32:0] e;
            @(negedge clk);
            #1;
            st_ready      = (st_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            mem_req_ready = (mem_mode == 0) ? 1'b1 : ((cyc % 2) == 0);
            ob = pend_q.size();
            if (rst_n && ob > 0 && (mem_mode == 0 || (cyc % 4) != 3)) begin
                d = dfun(pend_q.pop_front());
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = d;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            if (sum_clr) exp_sum = '0;
            else if (mem_rsp_valid) exp_sum = exp_sum + mem_rsp_data;
            if (pause_strm) chk(!st_valid, "R7", "valid while stream paused", 64'(st_valid), 0);
            if (pause_mem)  chk(!mem_req_valid, "R6", "request while memory paused", 64'(mem_req_valid), 0);
            if (mem_req_valid && mem_req_ready) begin
                chk(ob < lim_now, "R3", "outstanding at issue", 64'(ob), 64'(lim_now));
                chk((issued - delivered) < DEPTH, "R3", "words in flight at issue",
                    64'(issued - delivered), 64'(DEPTH));
                chk(mem_req_addr == exp_addr, "R2", "request address", 64'(mem_req_addr), 64'(exp_addr));
                exp_addr = exp_addr + 32'd4;
                issued++;
                pend_q.push_back(mem_req_addr);
            end
            if (st_valid && st_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected stream word", 64'(st_data), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(st_data == e[31:0], "R4", "stream data", 64'(st_data), 64'(e[31:0]));
                    chk(st_last == e[32], "R5", "last marker", 64'(st_last), 64'(e[32]));
                    delivered++;
                    if (exp_q.size() == 0) hs_last_cyc = cyc;
                end
            end
        end
    end

    // driver: pushes expected stream items when it starts a command
    task automatic launch(input logic [31:0] a, input int n, input bit eom,
                          input bit swp, input int mo);
        logic [31:0] base;
        @(negedge clk);
        base        = a & ~32'd3;
        cfg_addr    = a;
        cfg_words   = LEN_W'(n);
        cfg_eom     = eom;
        cfg_swap    = swp;
        cfg_max_out = 4'(mo);
        cfg_start   = 1'b1;
        lim_now     = (mo > 8) ? 9 : mo + 1;
        exp_addr    = base;
        issued      = 0;
        delivered   = 0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = dfun(base + 32'(4 * i));
            if (swp) w = rev(w);
            exp_q.push_back({eom && (i == n - 1), w});
        end
        @(negedge clk);
        cfg_start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", 64'(busy), 1);
    endtask

    task automatic wait_done();
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!done && t < 5000);
        chk(done == 1'b1, "R10", "done pulse seen", 64'(done), 1);
        chk(cyc == hs_last_cyc + 1, "R10", "done cycle", 64'(cyc), 64'(hs_last_cyc + 1));
        chk(exp_q.size() == 0, "R4", "words left in scoreboard", 64'(exp_q.size()), 0);
        chk(chksum == exp_sum, "R8", "checksum", 64'(chksum), 64'(exp_sum));
        @(negedge clk);
        chk(!done && !busy, "R10", "done and busy after pulse", 64'({done, busy}), 0);
    endtask

    initial begin
        logic [31:0] a1;
        rst_n = 1'b0; cfg_start = 1'b0; cfg_addr = '0; cfg_words = '0;
        cfg_eom = 1'b0; cfg_swap = 1'b0; cfg_max_out = '0;
        pause_mem = 1'b0; pause_strm = 1'b0; sum_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", "reset busy/done", 64'({busy, done}), 0);
        chk(!mem_req_valid && !st_valid, "R1", "reset request/stream", 64'({mem_req_valid, st_valid}), 0);
        chk(chksum == 0, "R8", "reset checksum", 64'(chksum), 0);

        // plain command, eom set, one outstanding read
        launch(32'h1000, 5, 1'b1, 1'b0, 0);
        wait_done();

        // misaligned start, swap, no eom, gappy handshakes; sum carries over
        mem_mode = 1; st_mode = 1;
        launch(32'h2003, 7, 1'b0, 1'b1, 3);
        wait_done();
        mem_mode = 0; st_mode = 0;

        // clear of the sum
        @(negedge clk); sum_clr = 1'b1;
        @(negedge clk); sum_clr = 1'b0;
        chk(chksum == 0, "R8", "checksum after clear", 64'(chksum), 0);

        // stream paused: FIFO room limits issue at DEPTH words
        pause_strm = 1'b1;
        launch(32'h4000, 30, 1'b1, 1'b0, 8);
        repeat (40) @(negedge clk);
        chk(issued == DEPTH, "R3", "issued with FIFO full", 64'(issued), 64'(DEPTH));
        chk(words_left == 30, "R9", "words left while stream paused", 64'(words_left), 30);
        chk(cur_addr == 32'h4000 + 32'(4 * DEPTH), "R9", "address while stream paused",
            64'(cur_addr), 64'(32'h4000 + 32'(4 * DEPTH)));
        pause_strm = 1'b0;
        repeat (3) @(negedge clk);
        sum_clr = 1'b1;   // lands among returning words: clear wins
        @(negedge clk);
        sum_clr = 1'b0;
        wait_done();

        // memory paused mid-run
        launch(32'h8000, 40, 1'b0, 1'b0, 1);
        repeat (12) @(negedge clk);
        pause_mem = 1'b1;
        repeat (6) @(negedge clk);
        a1 = cur_addr;
        chk(cur_addr == 32'h8000 + 32'(4 * issued), "R9", "address while memory paused",
            64'(cur_addr), 64'(32'h8000 + 32'(4 * issued)));
        chk(words_left == LEN_W'(40 - delivered), "R9", "words left while memory paused",
            64'(words_left), 64'(40 - delivered));
        chk(pend_q.size() == 0, "R6", "owed responses still returned", 64'(pend_q.size()), 0);
        repeat (5) @(negedge clk);
        chk(cur_addr == a1, "R6", "no issue while memory paused", 64'(cur_addr), 64'(a1));
        pause_mem = 1'b0;
        wait_done();

        // over-range limit code clamps to nine; stray start while busy
        launch(32'hA000, 12, 1'b1, 1'b0, 15);
        repeat (3) @(negedge clk);
        cfg_addr = 32'hF000; cfg_words = 3; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_done();
        chk(cur_addr == 32'hA000 + 32'd48, "R1", "start while busy ignored",
            64'(cur_addr), 64'(32'hA000 + 32'd48));

        // zero-length start ignored
        cfg_addr = 32'hC000; cfg_words = 0; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid, "R1", "zero-length start ignored",
            64'({busy, mem_req_valid}), 0);
        chk(cur_addr == 32'hA000 + 32'd48, "R1", "address after zero-length start",
            64'(cur_addr), 64'(32'hA000 + 32'd48));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule